// File: doc/BRIEF.md
# Instrument status byte and service-request logic

This block assembles the eight-bit status byte of a remote-controlled test instrument and raises a service request toward the controlling host. It folds four conditions into the byte: the error queue holds entries, the response queue holds data, the masked standard event register is non-zero, and the masked extended event register is non-zero. A host-written service request enable mask selects which of these conditions may ask for service. The enabled conditions are ORed into a master summary.

Bit 6 of the byte has two meanings, depending on how it is read. The serial-poll view carries a latched request flag. That flag is set when the master summary rises and cleared by a poll. The status-query view carries the live master summary. The request flag also drives the SRQ line.

The event registers, both queues, the transition filter and command decoding all live outside this block. They reach it as plain input vectors and flags. Every output comes from a register on the single clock. Inputs sampled at one rising edge show up on the outputs just after that edge.

Top module: `stb_service_req`

## Requirements
- R1: Bits 7, 1 and 0 of both `poll_byte` and `query_byte` are always 0.
- R2: Bit 2 (error available) of both bytes equals the inverse of `err_q_empty` sampled at the previous rising edge.
- R3: Bit 3 (extended summary) of both bytes is 1 exactly when `ext_evt & ext_en` was non-zero at the previous rising edge.
- R4: Bit 4 (message available) of both bytes equals the inverse of `out_q_empty` sampled at the previous rising edge.
- R5: Bit 5 (standard summary) of both bytes is 1 exactly when `std_evt & std_en` was non-zero at the previous rising edge.
- R6: Bit 6 of `query_byte` is the master summary. It is 1 exactly when bits 0 to 5 and bit 7 of the new status byte, ANDed with the enable mask held before that edge, give a non-zero result.
- R7: A status bit whose enable mask bit is 0 never sets the master summary or `srq`.
- R8: When the master summary goes from 0 to 1, the request flag becomes 1 at the same edge. `srq` and bit 6 of `poll_byte` both show the request flag.
- R9: With `poll_stb` high for one cycle, `poll_byte` in that cycle still shows the request flag, and the flag is 0 after that edge. It then stays 0 while the master summary stays 1, and is only set again by a new rise. A rise at the same edge as a poll sets the flag.
- R10: The request flag is cleared at the edge where the master summary becomes 0, without any poll.
- R11: With `sre_we` high at an edge, the enable mask takes `sre_wdata` with bit 6 forced to 0, and `sre_value` shows the stored mask after that edge.
- R12: While `rst_n` is low, every output and register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_q_empty | input | 1 | Error queue holds no entry |
| out_q_empty | input | 1 | Response queue holds no data |
| std_evt | input | STD_W | Standard event register contents |
| std_en | input | STD_W | Standard event enable mask |
| ext_evt | input | EXT_W | Extended event register contents |
| ext_en | input | EXT_W | Extended event enable mask |
| sre_we | input | 1 | Write strobe for the service request enable mask |
| sre_wdata | input | 8 | Data for the service request enable mask |
| poll_stb | input | 1 | Serial-poll strobe, one cycle per poll |
| poll_byte | output | 8 | Status byte for serial poll, request flag in bit 6 |
| query_byte | output | 8 | Status byte for status query, master summary in bit 6 |
| srq | output | 1 | Service request line, equal to the request flag |
| sre_value | output | 8 | Stored service request enable mask |

## Verification
The bench builds the block with both event vectors four bits wide and with the tree reduction selected. At that size it can drive every event/mask pair of each register and every combination of the two queue flags. It also walks all 256 enable mask values against all sixteen patterns of the four summary bits. Each mask step drops the summary to zero first, so the request flag sees thousands of fresh rises and falls. Directed sequences then cover the cases of the poll-and-clear rule: a poll while the summary stays high, a re-arm through a low summary, a fall without a poll, and a rise at the same edge as a poll.

// File: rtl/sb_pkg.sv
package sb_pkg;
   localparam int SB_W    = 8;
   localparam int B_EAV   = 2;
   localparam int B_EES   = 3;
   localparam int B_MAV   = 4;
   localparam int B_ESB   = 5;
   localparam int B_REQ   = 6;

   typedef logic [SB_W-1:0] sbyte_t;

   // Bits that take part in the master summary (all but the request bit).
   localparam sbyte_t SUMMARY_MASK = ~(sbyte_t'(1) << B_REQ);

   function automatic sbyte_t place_bit(input sbyte_t base, input int pos, input logic val);
      sbyte_t r;
      r = base;
      r[pos] = val;
      return r;
   endfunction
endpackage

// File: rtl/sb_masked_any.sv
module sb_masked_any #(
   parameter int W    = 8,
   parameter bit TREE = 1'b1
) (
   input  logic [W-1:0] vec,
   input  logic [W-1:0] msk,
   output logic         hit
);
   logic [W-1:0] both;
   assign both = vec & msk;

   generate
      if (TREE && W > 1) begin : g_tree
         localparam int LV = $clog2(W);
         localparam int P  = 1 << LV;
         for (genvar l = 0; l <= LV; l++) begin : g_lv
            logic [(P >> l)-1:0] v;
            if (l == 0) begin : g_leaf
               assign v = P'(both);
            end else begin : g_node
               for (genvar i = 0; i < (P >> l); i++) begin : g_or
                  assign v[i] = g_lv[l-1].v[2*i] | g_lv[l-1].v[2*i+1];
               end
            end
         end
         assign hit = g_lv[LV].v[0];
      end else begin : g_flat
         assign hit = |both;
      end
   endgenerate
endmodule

// File: rtl/sb_enable_reg.sv
module sb_enable_reg #(
   parameter int           W      = 8,
   parameter logic [W-1:0] ZERO_M = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & ~ZERO_M;
   end
endmodule

// File: rtl/sb_req_latch.sv
module sb_req_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic sum_next,
   input  logic sum_now,
   input  logic poll,
   output logic req_q
);
   logic req_d;

   always_comb begin
      if (!sum_next)     req_d = 1'b0;   // summary low: drop
      else if (!sum_now) req_d = 1'b1;   // rise wins over a poll
      else if (poll)     req_d = 1'b0;
      else               req_d = req_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= req_d;
   end
endmodule

// File: rtl/stb_service_req.sv
module stb_service_req
   import sb_pkg::*;
#(
   parameter int STD_W    = 8,
   parameter int EXT_W    = 16,
   parameter bit TREE_RED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_q_empty,
   input  logic             out_q_empty,
   input  logic [STD_W-1:0] std_evt,
   input  logic [STD_W-1:0] std_en,
   input  logic [EXT_W-1:0] ext_evt,
   input  logic [EXT_W-1:0] ext_en,
   input  logic             sre_we,
   input  logic [7:0]       sre_wdata,
   input  logic             poll_stb,
   output logic [7:0]       poll_byte,
   output logic [7:0]       query_byte,
   output logic             srq,
   output logic [7:0]       sre_value
);
   localparam sbyte_t SRE_ZERO = ~SUMMARY_MASK;

   generate
      if (STD_W < 1 || STD_W > 64) begin : g_bad_std
         $error("STD_W out of range");
      end
      if (EXT_W < 1 || EXT_W > 64) begin : g_bad_ext
         $error("EXT_W out of range");
      end
   endgenerate

   logic   ees_d, esb_d, sum_d, sum_q, req_q;
   sbyte_t st_d, st_q, sre_q;

   sb_masked_any #(.W(STD_W), .TREE(TREE_RED)) u_std (
      .vec(std_evt), .msk(std_en), .hit(esb_d));
   sb_masked_any #(.W(EXT_W), .TREE(TREE_RED)) u_ext (
      .vec(ext_evt), .msk(ext_en), .hit(ees_d));

   always_comb begin
      st_d = '0;
      st_d = place_bit(st_d, B_EAV, !err_q_empty);
      st_d = place_bit(st_d, B_EES, ees_d);
      st_d = place_bit(st_d, B_MAV, !out_q_empty);
      st_d = place_bit(st_d, B_ESB, esb_d);
   end

   sb_masked_any #(.W(SB_W), .TREE(TREE_RED)) u_sum (
      .vec(st_d), .msk(sre_q & SUMMARY_MASK), .hit(sum_d));

   sb_enable_reg #(.W(SB_W), .ZERO_M(SRE_ZERO)) u_sre (
      .clk(clk), .rst_n(rst_n), .we(sre_we), .wdata(sre_wdata), .q(sre_q));

   sb_req_latch u_req (
      .clk(clk), .rst_n(rst_n), .sum_next(sum_d), .sum_now(sum_q),
      .poll(poll_stb), .req_q(req_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= '0;
         sum_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         sum_q <= sum_d;
      end
   end

   assign poll_byte  = place_bit(st_q, B_REQ, req_q);
   assign query_byte = place_bit(st_q, B_REQ, sum_q);
   assign srq        = req_q;
   assign sre_value  = sre_q;
endmodule

// File: rtl/sb_chk.sv
module sb_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       err_q_empty,
   input logic       out_q_empty,
   input logic       poll_stb,
   input logic       srq,
   input logic [7:0] poll_byte,
   input logic [7:0] query_byte,
   input logic [7:0] sre_value
);
   a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_byte[7] == 1'b0 && poll_byte[1:0] == 2'b00 &&
       query_byte[7] == 1'b0 && query_byte[1:0] == 2'b00));

   a_r2_eav_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (query_byte[2] == !$past(err_q_empty)));

   a_r4_mav_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (poll_byte[4] == !$past(out_q_empty)));

   a_r8_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(query_byte[6]) |-> srq);

   a_r8_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(srq) |-> $rose(query_byte[6]));

   a_r9_poll_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_stb && srq) |=> !srq);

   a_r10_req_needs_sum: assert property (@(posedge clk) disable iff (!rst_n)
      srq |-> query_byte[6]);

   a_r11_bit6_stored_zero: assert property (@(posedge clk) disable iff (!rst_n)
      sre_value[6] == 1'b0);
endmodule

bind stb_service_req sb_chk u_chk (
   .clk(clk), .rst_n(rst_n), .err_q_empty(err_q_empty), .out_q_empty(out_q_empty),
   .poll_stb(poll_stb), .srq(srq), .poll_byte(poll_byte), .query_byte(query_byte),
   .sre_value(sre_value));

// File: tb/tb_stb_service_req.sv
module tb_stb_service_req;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 4;
   localparam int EW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          err_q_empty = 1'b1, out_q_empty = 1'b1;
   logic [SW-1:0] std_evt = '0, std_en = '0;
   logic [EW-1:0] ext_evt = '0, ext_en = '0;
   logic          sre_we = 1'b0, poll_stb = 1'b0;
   logic [7:0]    sre_wdata = '0;
   logic [7:0]    poll_byte, query_byte, sre_value;
   logic          srq;

   int total = 0;
   int bad   = 0;
   logic [7:0] e_st  = '0;
   logic [7:0] e_sre = '0;
   logic       e_sum = 1'b0;
   logic       e_req = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stb_service_req #(.STD_W(SW), .EXT_W(EW), .TREE_RED(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .err_q_empty(err_q_empty), .out_q_empty(out_q_empty),
      .std_evt(std_evt), .std_en(std_en), .ext_evt(ext_evt), .ext_en(ext_en),
      .sre_we(sre_we), .sre_wdata(sre_wdata), .poll_stb(poll_stb),
      .poll_byte(poll_byte), .query_byte(query_byte), .srq(srq), .sre_value(sre_value));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // Advances one edge with the inputs now driven; model built from the requirements.
   task automatic tick(input string tag);
      logic [7:0] st;
      logic       s_n, r_n;
      st = '0;
      st[2] = !err_q_empty;
      st[3] = |(ext_evt & ext_en);
      st[4] = !out_q_empty;
      st[5] = |(std_evt & std_en);
      s_n = |(st & e_sre & 8'hBF);
      if (!s_n)        r_n = 1'b0;
      else if (!e_sum) r_n = 1'b1;
      else if (poll_stb) r_n = 1'b0;
      else             r_n = e_req;
      if (sre_we) e_sre = sre_wdata & 8'hBF;
      e_st = st; e_sum = s_n; e_req = r_n;
      @(posedge clk);
      @(negedge clk);
      sre_we = 1'b0;
      poll_stb = 1'b0;
      chk({tag, " query"}, query_byte, e_st | {1'b0, e_sum, 6'b0});
      chk({tag, " poll"},  poll_byte,  e_st | {1'b0, e_req, 6'b0});
      chk({tag, " srq"},   {7'b0, srq}, {7'b0, e_req});
      chk({tag, " sre"},   sre_value,  e_sre);
   endtask

   task automatic set_flags(input logic [3:0] f);
      err_q_empty = !f[0]; out_q_empty = !f[2];
      ext_evt = f[1] ? 4'h1 : 4'h0; ext_en = 4'h1;
      std_evt = f[3] ? 4'h8 : 4'h0; std_en = 4'h8;
   endtask

   initial begin
      repeat (CLK_PERIOD * 15000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R12 reset state
      sre_we = 1'b1; sre_wdata = 8'hFF; err_q_empty = 1'b0;
      repeat (3) @(negedge clk);
      chk("R12 query", query_byte, 8'h00);
      chk("R12 poll", poll_byte, 8'h00);
      chk("R12 sre", sre_value, 8'h00);
      chk("R12 srq", {7'b0, srq}, 8'h00);
      sre_we = 1'b0; err_q_empty = 1'b1;
      rst_n = 1'b1;
      tick("R12 idle");

      // R2 R4: queue flags
      for (int f = 0; f < 4; f++) begin
         err_q_empty = f[0]; out_q_empty = f[1];
         tick("R2 R4 R1");
      end
      err_q_empty = 1'b1; out_q_empty = 1'b1;

      // R5: every standard event/mask pair
      for (int p = 0; p < 256; p++) begin
         std_evt = p[3:0]; std_en = p[7:4];
         tick("R5");
      end
      std_evt = '0; std_en = '0;

      // R3: every extended event/mask pair
      for (int p = 0; p < 256; p++) begin
         ext_evt = p[3:0]; ext_en = p[7:4];
         tick("R3");
      end
      ext_evt = '0; ext_en = '0;

      // R6 R7 R8 R11: every mask against every summary pattern
      for (int m = 0; m < 256; m++) begin
         for (int f = 0; f < 16; f++) begin
            set_flags(4'h0);
            tick("R10");
            sre_we = 1'b1; sre_wdata = m[7:0];
            tick("R11");
            set_flags(f[3:0]);
            tick("R6 R7 R8");
         end
      end

      // R9: poll while summary stays high, then re-arm
      set_flags(4'h0);
      sre_we = 1'b1; sre_wdata = 8'h10;
      tick("R11");
      out_q_empty = 1'b0;
      tick("R8");
      chk("R8 rise", {7'b0, srq}, 8'h01);
      poll_stb = 1'b1;
      #1 chk("R9 before clear", poll_byte, 8'h50);
      tick("R9");
      chk("R9 cleared", {7'b0, srq}, 8'h00);
      chk("R9 summary kept", query_byte, 8'h50);
      repeat (3) tick("R9 hold");
      chk("R9 stays clear", {7'b0, srq}, 8'h00);
      out_q_empty = 1'b1;
      tick("R10");
      out_q_empty = 1'b0;
      tick("R9 rearm");
      chk("R9 rearmed", {7'b0, srq}, 8'h01);

      // R10: summary falls without a poll
      out_q_empty = 1'b1;
      tick("R10");
      chk("R10 drop", {7'b0, srq}, 8'h00);

      // R9: rise at the same edge as a poll
      out_q_empty = 1'b0; poll_stb = 1'b1;
      tick("R9 same edge");
      chk("R9 rise wins", {7'b0, srq}, 8'h01);

      // R7: masked bit cannot request
      sre_we = 1'b1; sre_wdata = 8'hEF;
      tick("R7");
      tick("R7");
      chk("R7 masked", {7'b0, srq}, 8'h00);
      chk("R11 bit6", sre_value, 8'hAF);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule